// File: doc/BRIEF.md
# Reloading Down-Counter Timer

A memory-mapped countdown timer. It has four word registers: a load value, a read-only current count, a control word and an interrupt-clear strobe. When enabled, the counter steps down by one on each pulse of the tick source that is selected. The block takes a slow tick and a fast tick as single-cycle enable inputs, so clock division happens outside it. A tick that finds the counter at zero is an underflow. An underflow sets a sticky interrupt. The counter then either reloads from the load register (periodic mode) or wraps to all ones (free-running mode).

Software stops the timer by writing zero to control. It then writes the load value, which is also copied into the counter while the timer is stopped. Setting the enable bit starts the count. The interrupt service routine writes any value to the clear register. The counter width is a parameter, and 16-bit and 32-bit builds are both supported. Bus data is always 32 bits wide, and the count reads back zero-extended.

Top module: `cd_timer`

## Requirements
- R1: After reset, the load, value and control registers all read 0 and `irq_o` is 0.
- R2: Control uses bit 7 for enable, bit 6 for periodic mode and bit 3 for the fast tick. Every other control bit reads back 0, so writing 0xFFFFFFFF reads back 0xC8.
- R3: A write to the load register (word 0) always updates the load value that reads back. While enable is 0, the same write also copies the value into the counter. While enable is 1, the counter is left unchanged.
- R4: While enabled, the counter decrements by one on each pulse of the selected tick: `tick_fast_i` when bit 3 is 1, `tick_slow_i` when it is 0. Pulses on the other tick input have no effect.
- R5: While enable is 0 (for example after control is written with 0), no tick changes the counter.
- R6: A selected tick with the counter at 0 sets `irq_o` on the next cycle. In periodic mode (bit 6 = 1) that tick reloads the counter from the load register.
- R7: In free-running mode (bit 6 = 0), an underflow sets the counter to all ones and still sets `irq_o`.
- R8: `irq_o` stays set until a write to the clear register (word 3). Any data value clears it, and it reads 0 on the cycle after the write.
- R9: A clear write in the same cycle as an underflow leaves `irq_o` set.
- R10: The value register (word 1) is read-only, so writes to it leave the count unchanged.
- R11: With WIDTH=16, only the low 16 bits of a load write are kept, and a free-running underflow wraps the counter to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_slow_i | input | 1 | Slow tick enable, one-cycle pulses |
| tick_fast_i | input | 1 | Fast tick enable, one-cycle pulses |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address: 0 load, 1 value, 2 control, 3 clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Sticky underflow interrupt |

## Verification
The assertions check on every cycle how the counter moves:
- it holds unless a tick or a load-while-stopped occurs;
- it decrements by exactly one on a selected tick;
- it reloads or wraps on underflow, depending on the mode.

They also check that the interrupt rises only after an underflow, that a clear lowers it and that a colliding underflow keeps it set, and that unused control bits read 0. Only the bench scenarios can show the following:
- that the tick select and the enable gate real input sequences;
- that a load write behaves differently while stopped and while running;
- that writes to the value register are ignored;
- that a 16-bit build truncates and wraps correctly.

// File: rtl/cd_timer_pkg.sv
package cd_timer_pkg;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 2;
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_FAST_BIT = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LOAD  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_CLR   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic per;
    logic fast;
  } ctrl_t;
endpackage

// File: rtl/cd_timer_regs.sv
module cd_timer_regs
  import cd_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WIDTH-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [WIDTH-1:0]  load_o,
  output logic              ld_wr_o,
  output logic              clr_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e          sel;
  logic              ctrl_wr;
  logic [DATA_W-1:0] load_ext, cnt_ext;

  assign sel      = reg_sel_e'(addr_i);
  assign ld_wr_o  = wr_en_i && (sel == SEL_LOAD);
  assign ctrl_wr  = wr_en_i && (sel == SEL_CTRL);
  assign clr_wr_o = wr_en_i && (sel == SEL_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= '0;
      ctrl_o <= '0;
    end else begin
      if (ld_wr_o) load_o <= wdata_i[WIDTH-1:0];
      if (ctrl_wr) begin
        ctrl_o.en   <= wdata_i[CTRL_EN_BIT];
        ctrl_o.per  <= wdata_i[CTRL_PER_BIT];
        ctrl_o.fast <= wdata_i[CTRL_FAST_BIT];
      end
    end
  end

  generate
    if (WIDTH == DATA_W) begin : g_full
      assign load_ext = load_o;
      assign cnt_ext  = cnt_i;
    end else begin : g_pad
      assign load_ext = {{(DATA_W-WIDTH){1'b0}}, load_o};
      assign cnt_ext  = {{(DATA_W-WIDTH){1'b0}}, cnt_i};
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_LOAD:  rdata_o = load_ext;
      SEL_VALUE: rdata_o = cnt_ext;
      SEL_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = ctrl_o.en;
        rdata_o[CTRL_PER_BIT]  = ctrl_o.per;
        rdata_o[CTRL_FAST_BIT] = ctrl_o.fast;
      end
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cd_timer_core.sv
module cd_timer_core
  import cd_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             tick_slow_i,
  input  logic             tick_fast_i,
  input  logic             ld_wr_i,
  input  logic [WIDTH-1:0] ld_data_i,
  input  logic [WIDTH-1:0] load_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             uf_o
);
  logic tick, zero;

  assign tick = ctrl_i.en && (ctrl_i.fast ? tick_fast_i : tick_slow_i);
  assign zero = (cnt_o == '0);
  assign uf_o = tick && zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (ld_wr_i && !ctrl_i.en) begin
      cnt_o <= ld_data_i;  // preload while stopped
    end else if (tick) begin
      if (zero) cnt_o <= ctrl_i.per ? load_i : '1;
      else      cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/cd_timer_irq.sv
module cd_timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uf_i,
  input  logic clr_i,
  output logic irq_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= uf_i || (irq_o && !clr_i);
  end
endmodule

// File: rtl/cd_timer.sv
module cd_timer
  import cd_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [WIDTH-1:0] load_q, cnt_q;
  logic             ld_wr, clr_wr, uf;

  cd_timer_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .ctrl_o(ctrl), .load_o(load_q),
    .ld_wr_o(ld_wr), .clr_wr_o(clr_wr), .rdata_o
  );

  cd_timer_core #(.WIDTH(WIDTH)) u_core (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .tick_slow_i, .tick_fast_i,
    .ld_wr_i(ld_wr), .ld_data_i(wdata_i[WIDTH-1:0]), .load_i(load_q),
    .cnt_o(cnt_q), .uf_o(uf)
  );

  cd_timer_irq u_irq (
    .clk_i, .rst_ni, .uf_i(uf), .clr_i(clr_wr), .irq_o
  );
endmodule

// File: rtl/cd_timer_chk.sv
module cd_timer_chk
  import cd_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_slow_i,
  input logic              tick_fast_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input ctrl_t             ctrl_i,
  input logic [WIDTH-1:0]  load_i,
  input logic [WIDTH-1:0]  cnt_i,
  input logic              uf_i
);
  logic sel_tick, pre_ld, clr_w;
  assign sel_tick = ctrl_i.en && (ctrl_i.fast ? tick_fast_i : tick_slow_i);
  assign pre_ld   = wr_en_i && (addr_i == 2'd0) && !ctrl_i.en;
  assign clr_w    = wr_en_i && (addr_i == 2'd3);

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd2) |-> ((rdata_o & ~32'h0000_00C8) == '0)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_tick && !pre_ld) |=> $stable(cnt_i)); // R5
  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_tick && cnt_i != '0) |=> (cnt_i == $past(cnt_i) - 1'b1)); // R4
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_tick && cnt_i == '0 && ctrl_i.per) |=> (cnt_i == $past(load_i))); // R6
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_tick && cnt_i == '0 && !ctrl_i.per) |=> (&cnt_i)); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(uf_i)); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w && !uf_i) |=> !irq_o); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_w) |=> irq_o); // R8
  AST_CLR_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w && uf_i) |=> irq_o); // R9
endmodule

bind cd_timer cd_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_slow_i(tick_slow_i),
  .tick_fast_i(tick_fast_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .ctrl_i(ctrl), .load_i(load_q),
  .cnt_i(cnt_q), .uf_i(uf)
);

// File: tb/sim_cd_timer.sv
module sim_cd_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_s = 1'b0, tick_f = 1'b0;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cd_timer #(.WIDTH(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_slow_i(tick_s), .tick_fast_i(tick_f),
    .wr_en_i(wr0), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0), .irq_o(irq0)
  );
  cd_timer #(.WIDTH(16)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .tick_slow_i(tick_s), .tick_fast_i(tick_f),
    .wr_en_i(wr1), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .irq_o(irq1)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit inst, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (inst) wr1 = 1'b1; else wr0 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(bit inst, logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, inst ? rdata1 : rdata0, exp);
  endtask

  task automatic pulse(bit fast, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fast) tick_f = 1'b1; else tick_s = 1'b1;
      @(negedge clk);
      tick_f = 1'b0; tick_s = 1'b0;
    end
  endtask

  task automatic t_reset();
    rd(0, 2'd0, 32'h0, "R1 load");
    rd(0, 2'd1, 32'h0, "R1 value");
    rd(0, 2'd2, 32'h0, "R1 ctrl");
    check("R1 irq", {31'b0, irq0}, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(0, 2'd2, 32'hFFFF_FFFF);
    rd(0, 2'd2, 32'h0000_00C8, "R2 ctrl readback");
    wr(0, 2'd2, 32'h0);
    rd(0, 2'd2, 32'h0, "R2 ctrl zero");
  endtask

  task automatic t_load();
    wr(0, 2'd0, 32'd5);
    rd(0, 2'd1, 32'd5, "R3 preload value");
    rd(0, 2'd0, 32'd5, "R3 load readback");
    wr(0, 2'd2, 32'h0000_00C0);
    wr(0, 2'd0, 32'd9);
    rd(0, 2'd1, 32'd5, "R3 running load no copy");
    rd(0, 2'd0, 32'd9, "R3 running load reg");
    wr(0, 2'd1, 32'h77);
    rd(0, 2'd1, 32'd5, "R10 value read-only");
  endtask

  task automatic t_tick();
    pulse(0, 2);
    rd(0, 2'd1, 32'd3, "R4 slow ticks");
    pulse(1, 1);
    rd(0, 2'd1, 32'd3, "R4 fast ignored");
    wr(0, 2'd2, 32'h0000_00C8);
    pulse(1, 1);
    rd(0, 2'd1, 32'd2, "R4 fast tick");
    pulse(0, 1);
    rd(0, 2'd1, 32'd2, "R4 slow ignored");
  endtask

  task automatic t_stop();
    wr(0, 2'd2, 32'h0);
    pulse(0, 2);
    pulse(1, 2);
    rd(0, 2'd1, 32'd2, "R5 stopped");
  endtask

  task automatic t_periodic();
    wr(0, 2'd0, 32'd2);
    wr(0, 2'd2, 32'h0000_00C0);
    pulse(0, 2);
    rd(0, 2'd1, 32'd0, "R6 at zero");
    check("R6 no irq yet", {31'b0, irq0}, 32'h0);
    pulse(0, 1);
    rd(0, 2'd1, 32'd2, "R6 reload");
    check("R6 irq set", {31'b0, irq0}, 32'h1);
    pulse(0, 1);
    rd(0, 2'd1, 32'd1, "R6 counts on");
    check("R8 irq sticky", {31'b0, irq0}, 32'h1);
  endtask

  task automatic t_clear();
    wr(0, 2'd3, 32'h0000_DEAD);
    check("R8 clear", {31'b0, irq0}, 32'h0);
    wr(0, 2'd3, 32'h0);
    check("R8 clear idle", {31'b0, irq0}, 32'h0);
  endtask

  task automatic t_collide();
    pulse(0, 1);
    rd(0, 2'd1, 32'd0, "R9 at zero");
    @(negedge clk);
    addr = 2'd3; wdata = 32'h1; wr0 = 1'b1; tick_s = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; tick_s = 1'b0;
    check("R9 irq kept", {31'b0, irq0}, 32'h1);
    rd(0, 2'd1, 32'd2, "R9 reload");
    wr(0, 2'd3, 32'h0);
    check("R9 later clear", {31'b0, irq0}, 32'h0);
  endtask

  task automatic t_freerun();
    wr(0, 2'd2, 32'h0);
    wr(0, 2'd0, 32'd1);
    wr(0, 2'd2, 32'h0000_0080);
    pulse(0, 2);
    rd(0, 2'd1, 32'hFFFF_FFFF, "R7 wrap");
    check("R7 irq", {31'b0, irq0}, 32'h1);
    pulse(0, 1);
    rd(0, 2'd1, 32'hFFFF_FFFE, "R7 after wrap");
    wr(0, 2'd3, 32'h0);
  endtask

  task automatic t_w16();
    wr(1, 2'd0, 32'h0001_2345);
    rd(1, 2'd1, 32'h0000_2345, "R11 truncate value");
    rd(1, 2'd0, 32'h0000_2345, "R11 truncate load");
    wr(1, 2'd0, 32'h0);
    wr(1, 2'd2, 32'h0000_0088);
    pulse(1, 1);
    rd(1, 2'd1, 32'h0000_FFFF, "R11 wrap 16");
    check("R11 irq", {31'b0, irq1}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_load();
    t_tick();
    t_stop();
    t_periodic();
    t_clear();
    t_collide();
    t_freerun();
    t_w16();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule